// File: doc/BRIEF.md
# Programmable Interval Timer With Reload

This block is a periodic tick source that software controls through a small word-addressed register window. A 32-bit throttle value sets the period in bus clock cycles. While the timer runs, a counter climbs from zero. Each time the counter equals the active throttle value, the block emits a one-cycle tick pulse and the counter returns to zero.

The control word also holds an 8-bit interrupt number and a 4-bit priority. Both are driven out beside the tick, so an external interrupt encoder can route the event to any line. The intended software sequence is: stop the timer, write the throttle, then start it again. A throttle written while the timer runs is held and only used at the next reload.

Reads are combinational from the word address. The two low address bits are not decoded. A read-only word reports the bus clock period in whole nanoseconds, and that value is a build parameter.

Top module: `interval_tick_timer`

## Requirements
- R1: The control word (word 0) holds the run flag at bit 26, the priority at bits 23:20 and the interrupt number at bits 19:12. On a read, every other bit is zero whatever was written.
- R2: Writing the control word with bit 26 clear stops the timer. No tick occurs afterwards, and the count register keeps its value.
- R3: When bit 26 is written as 1 while the timer is stopped, the count goes to 0 and the throttle register is loaded as the active period. Writing 1 while the timer already runs does not restart it.
- R4: With active throttle T, the count climbs 0..T. In the clock after the count equals T, the tick pulse is high for one cycle and the count reads 0, giving one tick every T+1 cycles.
- R5: A throttle of 0 gives a tick on every clock while the timer runs.
- R6: A throttle write (word 4) made while the timer runs changes the period only from the next reload. Word 4 reads back the last value written.
- R7: Word 5 reads the current count. Words 1, 2, 3 and 7 read as zero, and writes to them have no effect.
- R8: Word 6 reads the parameter PERIOD_NS, and writes to it are ignored.
- R9: Byte address bits 1:0 are ignored on both reads and writes.
- R10: The outputs irqNum and irqPrio always equal the interrupt-number and priority fields of the control word.
- R11: After reset, every register and the count are zero and no tick is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access select |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from busAddr |
| tickPulse | output | 1 | One-cycle timer event |
| irqNum | output | 8 | Programmed interrupt number |
| irqPrio | output | 4 | Programmed priority |

## Verification
Read data is due in the same cycle as the address, so the bench compares it a short delay after the falling edge on which the address was driven. A write takes effect at the next rising edge. A run flag written to 1 clears the count at that edge. The first tick is high during the cycle that follows the edge T+1 clocks after the start. The bench's reference model advances on each rising edge, using the inputs held since the previous falling edge. The tick, the interrupt fields and the read data are compared against the model in every cycle, sampled at the same point after the falling edge, so each value is checked in the cycle it is due.

// File: rtl/itt_pkg.sv
package itt_pkg;
  localparam int RUN_BIT  = 26;
  localparam int PRIO_LSB = 20;
  localparam int PRIO_W   = 4;
  localparam int NUM_LSB  = 12;
  localparam int NUM_W    = 8;

  localparam int W_CTL = 0;
  localparam int W_THR = 4;
  localparam int W_CNT = 5;
  localparam int W_PER = 6;

  typedef struct packed {
    logic run;    // run flag as currently stored
    logic start;  // this edge turns a stopped timer on
  } tmr_strb_t;
endpackage

// File: rtl/itt_ctrl.sv
module itt_ctrl
  import itt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int PERIOD_NS = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   cntVal,
  output logic [DATA_W-1:0]   busRdata,
  output tmr_strb_t           strb,
  output logic [DATA_W-1:0]   thrShadow,
  output logic [NUM_W-1:0]    irqNum,
  output logic [PRIO_W-1:0]   irqPrio
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              wrCtl, wrThr, runQ;
  logic [DATA_W-1:0] ctlView;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrCtl   = busSel && busWr && (wordIdx == WORD_W'(W_CTL));
  assign wrThr   = busSel && busWr && (wordIdx == WORD_W'(W_THR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      irqNum    <= '0;
      irqPrio   <= '0;
      thrShadow <= '0;
    end else begin
      if (wrCtl) begin
        runQ    <= busWdata[RUN_BIT];
        irqNum  <= busWdata[NUM_LSB +: NUM_W];
        irqPrio <= busWdata[PRIO_LSB +: PRIO_W];
      end
      if (wrThr) thrShadow <= busWdata;
    end
  end

  assign strb.run   = runQ;
  assign strb.start = wrCtl && busWdata[RUN_BIT] && !runQ;

  always_comb begin
    ctlView = '0;
    ctlView[RUN_BIT]             = runQ;
    ctlView[NUM_LSB +: NUM_W]    = irqNum;
    ctlView[PRIO_LSB +: PRIO_W]  = irqPrio;
  end

  always_comb begin
    unique case (wordIdx)
      WORD_W'(W_CTL): busRdata = ctlView;
      WORD_W'(W_THR): busRdata = thrShadow;
      WORD_W'(W_CNT): busRdata = cntVal;
      WORD_W'(W_PER): busRdata = DATA_W'(PERIOD_NS);
      default:        busRdata = '0;
    endcase
  end
endmodule

// File: rtl/itt_datapath.sv
module itt_datapath
  import itt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strb_t         strb,
  input  logic [DATA_W-1:0] thrShadow,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] thrAct,
  output logic              tickPulse
);
  logic atLimit;

  assign atLimit = (cntVal == thrAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      thrAct    <= '0;
      tickPulse <= 1'b0;
    end else if (strb.start) begin
      cntVal    <= '0;
      thrAct    <= thrShadow;
      tickPulse <= 1'b0;
    end else if (strb.run) begin
      if (atLimit) begin
        cntVal    <= '0;
        thrAct    <= thrShadow;
        tickPulse <= 1'b1;
      end else begin
        cntVal    <= cntVal + 1'b1;
        tickPulse <= 1'b0;
      end
    end else begin
      tickPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer
  import itt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int PERIOD_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickPulse,
  output logic [7:0]        irqNum,
  output logic [3:0]        irqPrio
);
  tmr_strb_t         strb;
  logic [DATA_W-1:0] thrShadow, cntVal, thrAct;
  logic              stRun, stStart;

  assign stRun   = strb.run;
  assign stStart = strb.start;

  itt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD_NS(PERIOD_NS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .cntVal(cntVal), .busRdata(busRdata), .strb(strb),
    .thrShadow(thrShadow), .irqNum(irqNum), .irqPrio(irqPrio)
  );

  itt_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .thrShadow(thrShadow),
    .cntVal(cntVal), .thrAct(thrAct), .tickPulse(tickPulse)
  );
endmodule

// File: rtl/itt_checker.sv
module itt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              start,
  input logic [DATA_W-1:0] cntVal,
  input logic [DATA_W-1:0] thrAct,
  input logic              tickPulse
);
  a_r4_tick_with_zero: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> (cntVal == '0));

  a_r2_stopped_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !start) |=> !tickPulse);

  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !start) |=> $stable(cntVal));

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (cntVal == '0 && !tickPulse));

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cntVal <= thrAct));
endmodule

bind interval_tick_timer itt_checker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .run(stRun), .start(stStart),
  .cntVal(cntVal), .thrAct(thrAct), .tickPulse(tickPulse)
);

// File: tb/test_interval_tick_timer.sv
module test_interval_tick_timer;
  localparam int PER = 20;
  localparam logic [4:0] IDLE = 5'd20;

  logic clk = 0, rstN = 0, busSel = 0, busWr = 0;
  logic [4:0]  busAddr = IDLE;
  logic [31:0] busWdata = 0, busRdata;
  logic tickPulse;
  logic [7:0] irqNum;
  logic [3:0] irqPrio;

  int vecs = 0, errs = 0, pulses = 0;

  interval_tick_timer #(.PERIOD_NS(PER)) i_interval_tick_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickPulse(tickPulse),
    .irqNum(irqNum), .irqPrio(irqPrio));

  always #10 clk = ~clk;

  // behavioural reference
  logic [31:0] mCnt = 0, mAct = 0, mThr = 0;
  bit mEn = 0, mPulse = 0;
  logic [7:0] mNum = 0;
  logic [3:0] mPrio = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mAct = 0; mThr = 0; mEn = 0; mPulse = 0; mNum = 0; mPrio = 0;
    end else begin
      bit wr0, wr4;
      wr0 = busSel && busWr && busAddr[4:2] == 3'd0;
      wr4 = busSel && busWr && busAddr[4:2] == 3'd4;
      if (wr0 && busWdata[26] && !mEn) begin
        mCnt = 0; mAct = mThr; mPulse = 0;
      end else if (mEn) begin
        if (mCnt == mAct) begin mPulse = 1; mCnt = 0; mAct = mThr; end
        else begin mCnt = mCnt + 1; mPulse = 0; end
      end else mPulse = 0;
      if (wr0) begin mEn = busWdata[26]; mNum = busWdata[19:12]; mPrio = busWdata[23:20]; end
      if (wr4) mThr = busWdata;
    end
  end

  function automatic logic [31:0] expRead(logic [4:0] a);
    case (a[4:2])
      3'd0: return {5'd0, mEn, 2'd0, mPrio, mNum, 12'd0};
      3'd4: return mThr;
      3'd5: return mCnt;
      3'd6: return 32'(PER);
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(logic [4:0] a);
    case (a[4:2])
      3'd0: return "R1";
      3'd4: return "R6";
      3'd5: return "R4";
      3'd6: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      chk("R4", 32'(tickPulse), 32'(mPulse));
      chk("R10", 32'(irqNum), 32'(mNum));
      chk("R10", 32'(irqPrio), 32'(mPrio));
      chk(tagOf(busAddr), busRdata, expRead(busAddr));
      if (tickPulse) pulses++;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0; busAddr = IDLE;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #3; d = busRdata;
  endtask

  task automatic idle(int n);
    busAddr = IDLE;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d, c0;
    int p0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #3;
    // R11: reset state
    chk("R11", 32'(tickPulse), 0);
    rd(5'd0, d);  chk("R11", d, 0);
    rd(5'd16, d); chk("R11", d, 0);
    rd(5'd20, d); chk("R11", d, 0);
    rd(5'd24, d); chk("R8", d, PER);

    wr(5'd16, 32'd3);
    wr(5'd0, 32'h8000_0F01 | (32'd1 << 26) | (32'h2 << 20) | (32'h48 << 12));
    rd(5'd0, d); chk("R1", d, (32'd1 << 26) | (32'h2 << 20) | (32'h48 << 12));
    chk("R10", 32'(irqNum), 32'h48);
    chk("R10", 32'(irqPrio), 32'h2);

    // R4: period 4 -> 4 ticks in any 16-cycle window
    idle(3); p0 = pulses; idle(16); chk("R4", pulses - p0, 4);

    // R6: new throttle while running applies at next reload
    wr(5'd16, 32'd7);
    idle(8); p0 = pulses; idle(32); chk("R6", pulses - p0, 4);

    // R2: stop
    wr(5'd0, 32'd0);
    idle(2); rd(5'd20, c0); p0 = pulses;
    idle(10); rd(5'd20, d);
    chk("R2", d, c0); chk("R2", pulses - p0, 0);

    // R5: throttle zero, R3 restart
    wr(5'd16, 32'd0);
    wr(5'd0, 32'd1 << 26);
    idle(2); p0 = pulses; idle(10); chk("R5", pulses - p0, 10);
    wr(5'd0, 32'd0);

    // R7 / R8: unused words and read-only period
    wr(5'd8, 32'hDEAD_BEEF); rd(5'd8, d);  chk("R7", d, 0);
    rd(5'd28, d); chk("R7", d, 0);
    wr(5'd24, 32'd5);        rd(5'd24, d); chk("R8", d, PER);

    // R9: low address bits ignored
    wr(5'd19, 32'h55); rd(5'd18, d); chk("R9", d, 32'h55);
    wr(5'd2, (32'd1 << 26) | (32'h11 << 12)); rd(5'd1, d);
    chk("R9", d, (32'd1 << 26) | (32'h11 << 12));
    chk("R9", 32'(irqNum), 32'h11);
    // R3: re-enable while running does not restart the count
    idle(5); rd(5'd20, c0);
    wr(5'd0, (32'd1 << 26) | (32'h11 << 12));
    rd(5'd20, d); chk("R3", d, (c0 + 3) % 32'h56);
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule